// File: doc/BRIEF.md
# Accumulator Datapath with Extended Carry Bit

This block holds a processor's working accumulator together with a one-bit extension flag that catches the carry out of additions and takes part in rotations. Each clock cycle it applies at most one operation to the accumulator and the flag. The operation comes from a one-hot control vector. The operations are a bitwise AND with a data operand, an add that writes its carry into the flag, a plain load of the operand, a low-byte load from a narrow input port, a complement, rotations in both directions through the flag, an increment, an accumulator clear, a flag clear and a flag complement.

The next accumulator value comes from a row of identical per-bit slices. Each slice has its own full adder and the slices form a ripple carry chain. The register itself has separate load, increment and clear enables. Increment and clear act directly on the register. Every other operation loads the slice outputs. Zero and sign status come combinationally from the registered accumulator. When more than one control bit is raised in a cycle, the block makes no change to its state and raises an error output for that cycle.

Top module: `accum_datapath`

## Requirements
- R1: While rst_n is low (asynchronous, active low) the accumulator is 0 and the extension flag is 0.
- R2: op_i bit 0 (AND) gives acc = acc & dr_i on the next edge. The flag is unchanged.
- R3: op_i bit 1 (ADD) gives {flag, acc} = acc + dr_i. The carry out of the top bit lands in the flag, and no carry clears it.
- R4: op_i bit 2 (LOAD) gives acc = dr_i. The flag is unchanged.
- R5: op_i bit 3 (INPUT) writes inp_i into acc[IN_W-1:0]. acc[DATA_W-1:IN_W] keeps its value and the flag is unchanged.
- R6: op_i bit 4 (CPL) inverts every accumulator bit. The flag is unchanged.
- R7: op_i bit 5 (ROTR) gives acc = {flag, acc[DATA_W-1:1]} and flag = old acc[0].
- R8: op_i bit 6 (ROTL) gives acc = {acc[DATA_W-2:0], flag} and flag = old acc[DATA_W-1].
- R9: op_i bit 7 (INC) adds one to acc. The flag is unchanged, even when acc wraps from all ones to zero.
- R10: op_i bit 8 (CLR) sets acc to zero. The flag is unchanged.
- R11: op_i bit 9 (CLRE) clears the flag and op_i bit 10 (CPLE) inverts it. The accumulator is unchanged by both.
- R12: With op_i all zero, acc and the flag hold.
- R13: With two or more op_i bits set, multi_err_o is high in that same cycle, and acc and the flag hold through the next edge.
- R14: zero_o is high exactly when acc is zero. sign_o equals acc[DATA_W-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 11 | One-hot operation select (bit map in R2 to R11) |
| dr_i | input | DATA_W | Data operand |
| inp_i | input | IN_W | Narrow input character |
| acc_o | output | DATA_W | Registered accumulator |
| ext_o | output | 1 | Registered extension (carry) flag |
| zero_o | output | 1 | Accumulator equals zero |
| sign_o | output | 1 | Top bit of the accumulator |
| multi_err_o | output | 1 | More than one operation requested this cycle |

## Verification
The bound checker compares every accepted operation against the accumulator and flag one edge later. This covers the arithmetic result with its carry, both rotation directions with their flag hand-off, the preserved high byte on an input transfer, and the hold on idle or conflicting requests. What only the bench scenarios show is chained behaviour: a carry set by an add and then consumed by a rotate, an increment wrapping while the flag is deliberately set, the status outputs following a long run of mixed operations, and a reset arriving in the middle of a sequence.

// File: rtl/accum_pkg.sv
package accum_pkg;

   localparam int OP_AND   = 0;
   localparam int OP_ADD   = 1;
   localparam int OP_LOAD  = 2;
   localparam int OP_INPUT = 3;
   localparam int OP_CPL   = 4;
   localparam int OP_ROTR  = 5;
   localparam int OP_ROTL  = 6;
   localparam int OP_INC   = 7;
   localparam int OP_CLR   = 8;
   localparam int OP_CLRE  = 9;
   localparam int OP_CPLE  = 10;
   localparam int NUM_OPS  = 11;

   // function applied by every bit slice
   typedef enum logic [2:0] {
      FN_HOLD, FN_AND, FN_ADD, FN_PASS, FN_INPUT, FN_CPL, FN_ROTR, FN_ROTL
   } slice_fn_t;

   // source of the next extension flag value
   typedef enum logic [2:0] {
      E_HOLD, E_CARRY, E_LSB, E_MSB, E_ZERO, E_FLIP
   } ext_src_t;

   typedef struct packed {
      slice_fn_t fn;
      logic      ld;
      logic      inr;
      logic      clr;
      ext_src_t  e_src;
   } acc_ctl_t;

endpackage

// File: rtl/accum_bit_slice.sv
module accum_bit_slice
   import accum_pkg::*;
(
   input  slice_fn_t fn_i,
   input  logic      ac_b,
   input  logic      up_b,   // neighbour above (flag at the top)
   input  logic      dn_b,   // neighbour below (flag at the bottom)
   input  logic      dr_b,
   input  logic      inp_b,
   input  logic      cin,
   output logic      nxt_b,
   output logic      cout
);

   logic half;

   assign half = ac_b ^ dr_b;
   assign cout = (ac_b & dr_b) | (cin & half);

   always_comb begin
      case (fn_i)
         FN_AND:   nxt_b = ac_b & dr_b;
         FN_ADD:   nxt_b = half ^ cin;
         FN_PASS:  nxt_b = dr_b;
         FN_INPUT: nxt_b = inp_b;
         FN_CPL:   nxt_b = ~ac_b;
         FN_ROTR:  nxt_b = up_b;
         FN_ROTL:  nxt_b = dn_b;
         default:  nxt_b = ac_b;
      endcase
   end

endmodule

// File: rtl/accum_logic_array.sv
module accum_logic_array
   import accum_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input  slice_fn_t         fn_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              ext_i,
   input  logic [DATA_W-1:0] dr_i,
   input  logic [IN_W-1:0]   inp_i,
   output logic [DATA_W-1:0] nxt_o,
   output logic              carry_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   carry;
   logic [DATA_W-1:0] up_bits;
   logic [DATA_W-1:0] dn_bits;
   logic [DATA_W-1:0] inp_bits;

   assign carry[0] = 1'b0;
   assign carry_o  = carry[DATA_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      // neighbours for rotation: the flag closes the ring
      if (i == MSB) begin : g_top
         assign up_bits[i] = ext_i;
      end else begin : g_mid_up
         assign up_bits[i] = acc_i[i+1];
      end
      if (i == 0) begin : g_bot
         assign dn_bits[i] = ext_i;
      end else begin : g_mid_dn
         assign dn_bits[i] = acc_i[i-1];
      end
      // bits above the input width keep their value on an input transfer
      if (i < IN_W) begin : g_inp
         assign inp_bits[i] = inp_i[i];
      end else begin : g_keep
         assign inp_bits[i] = acc_i[i];
      end

      accum_bit_slice u_slice (
         .fn_i  (fn_i),
         .ac_b  (acc_i[i]),
         .up_b  (up_bits[i]),
         .dn_b  (dn_bits[i]),
         .dr_b  (dr_i[i]),
         .inp_b (inp_bits[i]),
         .cin   (carry[i]),
         .nxt_b (nxt_o[i]),
         .cout  (carry[i+1])
      );
   end

endmodule

// File: rtl/accum_op_decode.sv
module accum_op_decode
   import accum_pkg::*;
(
   input  logic [NUM_OPS-1:0] op_i,
   output acc_ctl_t           ctl_o,
   output logic               multi_o
);

   // more than one bit set: clearing the lowest set bit leaves something
   assign multi_o = |(op_i & (op_i - NUM_OPS'(1)));

   always_comb begin
      ctl_o.fn    = FN_HOLD;
      ctl_o.ld    = 1'b0;
      ctl_o.inr   = 1'b0;
      ctl_o.clr   = 1'b0;
      ctl_o.e_src = E_HOLD;
      if (!multi_o) begin
         if (op_i[OP_AND]) begin
            ctl_o.fn = FN_AND;   ctl_o.ld = 1'b1;
         end
         if (op_i[OP_ADD]) begin
            ctl_o.fn = FN_ADD;   ctl_o.ld = 1'b1; ctl_o.e_src = E_CARRY;
         end
         if (op_i[OP_LOAD]) begin
            ctl_o.fn = FN_PASS;  ctl_o.ld = 1'b1;
         end
         if (op_i[OP_INPUT]) begin
            ctl_o.fn = FN_INPUT; ctl_o.ld = 1'b1;
         end
         if (op_i[OP_CPL]) begin
            ctl_o.fn = FN_CPL;   ctl_o.ld = 1'b1;
         end
         if (op_i[OP_ROTR]) begin
            ctl_o.fn = FN_ROTR;  ctl_o.ld = 1'b1; ctl_o.e_src = E_LSB;
         end
         if (op_i[OP_ROTL]) begin
            ctl_o.fn = FN_ROTL;  ctl_o.ld = 1'b1; ctl_o.e_src = E_MSB;
         end
         if (op_i[OP_INC])  ctl_o.inr   = 1'b1;
         if (op_i[OP_CLR])  ctl_o.clr   = 1'b1;
         if (op_i[OP_CLRE]) ctl_o.e_src = E_ZERO;
         if (op_i[OP_CPLE]) ctl_o.e_src = E_FLIP;
      end
   end

endmodule

// File: rtl/accum_reg.sv
module accum_reg
   import accum_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic              inr_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] d_i,
   input  ext_src_t          e_src_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] acc_q,
   output logic              ext_q
);

   localparam int MSB = DATA_W - 1;

   logic ext_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (inr_i) acc_q <= acc_q + DATA_W'(1);
      else if (ld_i)  acc_q <= d_i;
   end

   always_comb begin
      case (e_src_i)
         E_CARRY: ext_nxt = carry_i;
         E_LSB:   ext_nxt = acc_q[0];
         E_MSB:   ext_nxt = acc_q[MSB];
         E_ZERO:  ext_nxt = 1'b0;
         E_FLIP:  ext_nxt = ~ext_q;
         default: ext_nxt = ext_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= 1'b0;
      else        ext_q <= ext_nxt;
   end

endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
   import accum_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OPS-1:0] op_i,
   input  logic [DATA_W-1:0]  dr_i,
   input  logic [IN_W-1:0]    inp_i,
   output logic [DATA_W-1:0]  acc_o,
   output logic               ext_o,
   output logic               zero_o,
   output logic               sign_o,
   output logic               multi_err_o
);

   if (DATA_W < 2) begin : g_bad_width
      $error("accum_datapath: DATA_W must be at least 2");
   end
   if (IN_W < 1 || IN_W > DATA_W) begin : g_bad_inp
      $error("accum_datapath: IN_W must lie in 1..DATA_W");
   end

   acc_ctl_t          ctl;
   logic [DATA_W-1:0] nxt;
   logic              carry;
   logic [DATA_W-1:0] acc_q;
   logic              ext_q;

   accum_op_decode u_dec (
      .op_i    (op_i),
      .ctl_o   (ctl),
      .multi_o (multi_err_o)
   );

   accum_logic_array #(.DATA_W(DATA_W), .IN_W(IN_W)) u_logic (
      .fn_i    (ctl.fn),
      .acc_i   (acc_q),
      .ext_i   (ext_q),
      .dr_i    (dr_i),
      .inp_i   (inp_i),
      .nxt_o   (nxt),
      .carry_o (carry)
   );

   accum_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_i    (ctl.ld),
      .inr_i   (ctl.inr),
      .clr_i   (ctl.clr),
      .d_i     (nxt),
      .e_src_i (ctl.e_src),
      .carry_i (carry),
      .acc_q   (acc_q),
      .ext_q   (ext_q)
   );

   assign acc_o  = acc_q;
   assign ext_o  = ext_q;
   assign zero_o = ~|acc_q;
   assign sign_o = acc_q[DATA_W-1];

endmodule

// File: rtl/accum_checker.sv
module accum_checker
   import accum_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OPS-1:0] op_i,
   input logic [DATA_W-1:0]  dr_i,
   input logic [IN_W-1:0]    inp_i,
   input logic [DATA_W-1:0]  acc_o,
   input logic               ext_o,
   input logic               zero_o,
   input logic               sign_o,
   input logic               multi_err_o
);

   localparam logic [NUM_OPS-1:0] M_AND   = NUM_OPS'(1) << OP_AND;
   localparam logic [NUM_OPS-1:0] M_ADD   = NUM_OPS'(1) << OP_ADD;
   localparam logic [NUM_OPS-1:0] M_LOAD  = NUM_OPS'(1) << OP_LOAD;
   localparam logic [NUM_OPS-1:0] M_INPUT = NUM_OPS'(1) << OP_INPUT;
   localparam logic [NUM_OPS-1:0] M_CPL   = NUM_OPS'(1) << OP_CPL;
   localparam logic [NUM_OPS-1:0] M_ROTR  = NUM_OPS'(1) << OP_ROTR;
   localparam logic [NUM_OPS-1:0] M_ROTL  = NUM_OPS'(1) << OP_ROTL;
   localparam logic [NUM_OPS-1:0] M_INC   = NUM_OPS'(1) << OP_INC;
   localparam logic [NUM_OPS-1:0] M_CLR   = NUM_OPS'(1) << OP_CLR;
   localparam logic [NUM_OPS-1:0] M_CLRE  = NUM_OPS'(1) << OP_CLRE;
   localparam logic [NUM_OPS-1:0] M_CPLE  = NUM_OPS'(1) << OP_CPLE;
   localparam logic [DATA_W-1:0]  LO_MASK = {DATA_W{1'b1}} >> (DATA_W - IN_W);
   localparam int                 MSB     = DATA_W - 1;

   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> (acc_o == '0 && !ext_o));

   a_r2_and: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_AND |=> acc_o == ($past(acc_o) & $past(dr_i)) && $stable(ext_o));

   a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_ADD |=> {ext_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(dr_i)}));

   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_LOAD |=> acc_o == $past(dr_i) && $stable(ext_o));

   a_r5_input: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_INPUT |=> acc_o == (($past(acc_o) & ~LO_MASK) | DATA_W'($past(inp_i)))
                          && $stable(ext_o));

   a_r6_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_CPL |=> acc_o == ~$past(acc_o) && $stable(ext_o));

   a_r7_rotr: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_ROTR |=> acc_o == {$past(ext_o), $past(acc_o[MSB:1])}
                         && ext_o == $past(acc_o[0]));

   a_r8_rotl: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_ROTL |=> acc_o == {$past(acc_o[MSB-1:0]), $past(ext_o)}
                         && ext_o == $past(acc_o[MSB]));

   a_r9_inc: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_INC |=> acc_o == $past(acc_o) + DATA_W'(1) && $stable(ext_o));

   a_r10_clr: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_CLR |=> acc_o == '0 && $stable(ext_o));

   a_r11_clre: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_CLRE |=> !ext_o && $stable(acc_o));

   a_r11_cple: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_CPLE |=> ext_o != $past(ext_o) && $stable(acc_o));

   a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == '0 |=> $stable(acc_o) && $stable(ext_o));

   a_r13_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(op_i) > 1 |-> multi_err_o);

   a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(op_i) > 1 |=> $stable(acc_o) && $stable(ext_o));

   a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(op_i) <= 1 |-> !multi_err_o);

   a_r14_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_CLR |=> zero_o && !sign_o);

   a_r14_sign: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == M_LOAD |=> sign_o == $past(dr_i[MSB]) && zero_o == ($past(dr_i) == '0));

endmodule

bind accum_datapath accum_checker #(.DATA_W(DATA_W), .IN_W(IN_W)) u_accum_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_i        (op_i),
   .dr_i        (dr_i),
   .inp_i       (inp_i),
   .acc_o       (acc_o),
   .ext_o       (ext_o),
   .zero_o      (zero_o),
   .sign_o      (sign_o),
   .multi_err_o (multi_err_o)
);

// File: tb/tb_accum_datapath.sv
`timescale 1ns/1ps
module tb_accum_datapath;

   localparam int DW = 16;
   localparam int IW = 8;
   localparam int NV = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [10:0]   op = '0;
   logic [DW-1:0] dr = '0;
   logic [IW-1:0] inp = '0;
   logic [DW-1:0] acc;
   logic          ext, zero, sign, merr;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;
   logic [51:0] vec;

   always #4 clk = ~clk;

   accum_datapath #(.DATA_W(DW), .IN_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .op_i(op), .dr_i(dr), .inp_i(inp),
      .acc_o(acc), .ext_o(ext), .zero_o(zero), .sign_o(sign), .multi_err_o(merr)
   );

   // fields: op[51:41] dr[40:25] inp[24:17] expected acc[16:1] expected flag[0]
   localparam logic [51:0] VEC [NV] = '{
      {11'h004, 16'hA5C3, 8'h00, 16'hA5C3, 1'b0},  // R4 load
      {11'h001, 16'h0FF0, 8'h00, 16'h05C0, 1'b0},  // R2 and
      {11'h002, 16'hFA40, 8'h00, 16'h0000, 1'b1},  // R3 add with carry out
      {11'h008, 16'h0000, 8'h7E, 16'h007E, 1'b1},  // R5 input
      {11'h004, 16'h1234, 8'h00, 16'h1234, 1'b1},  // R4
      {11'h008, 16'hFFFF, 8'hAB, 16'h12AB, 1'b1},  // R5 high byte kept
      {11'h010, 16'h0000, 8'h00, 16'hED54, 1'b1},  // R6
      {11'h020, 16'h0000, 8'h00, 16'hF6AA, 1'b0},  // R7 flag into top bit
      {11'h040, 16'h0000, 8'h00, 16'hED54, 1'b1},  // R8
      {11'h040, 16'h0000, 8'h00, 16'hDAA9, 1'b1},  // R8 flag into bit 0
      {11'h200, 16'h0000, 8'h00, 16'hDAA9, 1'b0},  // R11 clear flag
      {11'h400, 16'h0000, 8'h00, 16'hDAA9, 1'b1},  // R11 flip flag
      {11'h002, 16'h2556, 8'h00, 16'hFFFF, 1'b0},  // R3 no carry clears flag
      {11'h400, 16'h0000, 8'h00, 16'hFFFF, 1'b1},  // R11
      {11'h080, 16'h0000, 8'h00, 16'h0000, 1'b1},  // R9 wrap keeps flag
      {11'h000, 16'hBEEF, 8'h55, 16'h0000, 1'b1},  // R12 idle
      {11'h004, 16'h8001, 8'h00, 16'h8001, 1'b1},  // R4
      {11'h104, 16'h5555, 8'h00, 16'h8001, 1'b1},  // R13 load+clear conflict
      {11'h600, 16'h0000, 8'h00, 16'h8001, 1'b1},  // R13 flag ops conflict
      {11'h100, 16'h0000, 8'h00, 16'h0000, 1'b1},  // R10
      {11'h002, 16'h0000, 8'h00, 16'h0000, 1'b0}   // R3 zero plus zero
   };

   function automatic string req_of(input logic [10:0] o);
      case (o)
         11'h001: return "R2";
         11'h002: return "R3";
         11'h004: return "R4";
         11'h008: return "R5";
         11'h010: return "R6";
         11'h020: return "R7";
         11'h040: return "R8";
         11'h080: return "R9";
         11'h100: return "R10";
         11'h200, 11'h400: return "R11";
         11'h000: return "R12";
         default: return "R13";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1 acc", 32'(acc), 32'h0);
      chk("R1 flag", 32'(ext), 32'h0);
      @(negedge clk) rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         vec = VEC[k];
         @(negedge clk);
         op  = vec[51:41];
         dr  = vec[40:25];
         inp = vec[24:17];
         #1;
         chk({req_of(op), " error flag"}, 32'(merr), 32'($countones(op) > 1));
         @(posedge clk);
         #2;
         chk({req_of(vec[51:41]), " acc"}, 32'(acc), 32'(vec[16:1]));
         chk({req_of(vec[51:41]), " flag"}, 32'(ext), 32'(vec[0]));
         chk("R14 zero", 32'(zero), 32'(vec[16:1] == 16'h0));
         chk("R14 sign", 32'(sign), 32'(vec[16]));
      end

      // R1: reset in the middle of a run, asynchronous
      @(negedge clk);
      op = 11'h004; dr = 16'hFFFF;
      @(posedge clk); #2;
      chk("R4 acc before reset", 32'(acc), 32'hFFFF);
      @(negedge clk);
      op = 11'h400;
      rst_n = 1'b0;
      #1;
      chk("R1 async acc", 32'(acc), 32'h0);
      chk("R1 async flag", 32'(ext), 32'h0);
      @(posedge clk); #2;
      chk("R1 held acc", 32'(acc), 32'h0);
      chk("R14 zero after reset", 32'(zero), 32'h1);
      @(negedge clk);
      op = '0;
      rst_n = 1'b1;

      // R5 with the high byte set, flag untouched
      @(negedge clk);
      op = 11'h004; dr = 16'hC300;
      @(negedge clk);
      op = 11'h008; inp = 8'h0F;
      @(posedge clk); #2;
      chk("R5 acc", 32'(acc), 32'hC30F);
      chk("R5 flag", 32'(ext), 32'h0);

      @(negedge clk) op = '0;
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule